// File: doc/BRIEF.md
# SHA-256 Schedule Partial-Expansion Unit

This unit carries out the first half of the SHA-256 message-schedule recurrence for four 32-bit lanes at once. Operand A holds four consecutive schedule words. Operand B provides one more word, the one that follows them, in its lowest dword. Each result lane is a word plus the small-sigma-0 function of the word after it. A later schedule step adds the remaining terms.

The datapath has one registered stage. A caller presents both operands with `in_valid_i` high. One clock later, `out_valid_o` rises and `result_o` carries the four sums. The result is meant to be written back into the storage that supplied operand A. The unit has no status or flag outputs.

Top module: `sha2_sched_pre`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first accepted input, `out_valid_o` is 0.
- R2: Word k, for k = 0..3, is `src_a_i[32k+31:32k]`. Word 4 is `src_b_i[31:0]`.
- R3: Result lane i, for i = 0..3, sits at `result_o[32i+31:32i]` and equals word i + sig0(word i+1), modulo 2^32.
- R4: `src_b_i[127:32]` has no effect on `result_o`.
- R5: `out_valid_o` is high in exactly the cycle that follows a cycle with `in_valid_i` high, and is low otherwise.
- R6: When `in_valid_i` is low, `result_o` keeps its previous value in the next cycle.
- R7: A carry out of one lane's 32-bit sum is dropped and never enters the next lane.
- R8: sig0(x) = rotr(x,7) XOR rotr(x,18) XOR (x >> 3), on 32-bit x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are valid this cycle |
| src_a_i | input | 128 | Four schedule words, word 0 in the low dword |
| src_b_i | input | 128 | Only the low dword (word 4) is used |
| out_valid_o | output | 1 | Result is valid |
| result_o | output | 128 | Four partial-expansion sums, lane 0 in the low dword |

## Verification
The hardest cases to reach are a carry out of one lane, which must be dropped (R7), and a rotation or shift amount that is off by one in a single term of sig0, which random data seldom singles out. The stimulus uses all-ones operands, which overflow every lane. It then sweeps a single set bit through every position of every one of the five words, so that each term of sig0 and each word-to-lane route is exposed on its own. Random operands are then applied with random upper dwords in operand B. Pairs of runs that differ only in those upper dwords show that they have no effect.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = WORD_W * LANES;
  localparam int unsigned ROT_A  = 7;
  localparam int unsigned ROT_B  = 18;
  localparam int unsigned SHR_C  = 3;

  typedef logic [WORD_W-1:0] word_t;

  // Reference form for assertions; written as a doubled-word slice
  function automatic word_t sig0_ref(input word_t x);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x};
    return dbl[ROT_A +: WORD_W] ^ dbl[ROT_B +: WORD_W] ^ word_t'(x >> SHR_C);
  endfunction
endpackage

// File: rtl/sha2_sig0.sv
module sha2_sig0 #(
  parameter int unsigned W  = 32,
  parameter int unsigned RA = 7,
  parameter int unsigned RB = 18,
  parameter int unsigned SC = 3
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] rot_a, rot_b, shr_c;

  always_comb begin
    rot_a = (x_i >> RA) | (x_i << (W - RA));
    rot_b = (x_i >> RB) | (x_i << (W - RB));
    shr_c = x_i >> SC;
    y_o   = rot_a ^ rot_b ^ shr_c;
  end
endmodule

// File: rtl/sha2_lane_add.sv
module sha2_lane_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // carry out is dropped: lanes stay isolated
  always_comb sum_o = a_i + b_i;
endmodule

// File: rtl/sha2_pipe_reg.sv
module sha2_pipe_reg #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/sha2_sched_pre.sv
module sha2_sched_pre
  import sha2_sched_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] result_o
);
  word_t            words [LANES+1];
  logic [VEC_W-1:0] sum_vec;

  always_comb begin
    for (int k = 0; k < LANES; k++) words[k] = src_a_i[k*WORD_W +: WORD_W];
    words[LANES] = src_b_i[WORD_W-1:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    word_t sig;

    sha2_sig0 #(.W(WORD_W), .RA(ROT_A), .RB(ROT_B), .SC(SHR_C)) i_sig (
      .x_i (words[g+1]),
      .y_o (sig)
    );

    sha2_lane_add #(.W(WORD_W)) i_add (
      .a_i   (words[g]),
      .b_i   (sig),
      .sum_o (sum_vec[g*WORD_W +: WORD_W])
    );

    assert_lane_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> result_o[g*WORD_W +: WORD_W] ==
        $past(src_a_i[g*WORD_W +: WORD_W] + sig0_ref(
          (g == LANES-1) ? src_b_i[WORD_W-1:0] : src_a_i[(g+1)*WORD_W +: WORD_W])));
  end

  sha2_pipe_reg #(.W(VEC_W)) i_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (sum_vec),
    .valid_o (out_valid_o),
    .data_o  (result_o)
  );

  assert_valid_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
endmodule

// File: tb/test_sha2_sched_pre.sv
`timescale 1ns/1ps
module test_sha2_sched_pre;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic         out_valid_o;
  logic [127:0] result_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sha2_sched_pre i_sha2_sched_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .out_valid_o(out_valid_o), .result_o(result_o)
  );

  // R8 model
  function automatic logic [31:0] m_sig0(input logic [31:0] x);
    return ((x >> 7) | (x << 25)) ^ ((x >> 18) | (x << 14)) ^ (x >> 3);
  endfunction

  // R2, R3, R7 model
  function automatic logic [127:0] m_expect(input logic [127:0] a, input logic [127:0] b);
    logic [31:0] w [5];
    logic [127:0] r;
    for (int k = 0; k < 4; k++) w[k] = a[32*k +: 32];
    w[4] = b[31:0];
    for (int i = 0; i < 4; i++) r[32*i +: 32] = w[i] + m_sig0(w[i+1]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input string req);
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(out_valid_o === 1'b1, "R5 valid", {127'd0, out_valid_o}, 128'd1);
    chk(result_o === m_expect(a, b), req, result_o, m_expect(a, b));
  endtask

  initial begin
    logic [127:0] keep, a, b, r1;
    #1;
    chk(out_valid_o === 1'b0, "R1 in reset", {127'd0, out_valid_o}, 128'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R1 after reset", {127'd0, out_valid_o}, 128'd0);

    apply('0, '0, "R3 zeros");
    apply('1, '1, "R7 all ones carry");
    apply({4{32'hffff_ffff}}, {96'd0, 32'h0000_0001}, "R7 lane overflow");

    // single-bit sweep over five words (R2, R8)
    for (int wd = 0; wd < 5; wd++)
      for (int bt = 0; bt < 32; bt++) begin
        a = '0; b = '0;
        if (wd < 4) a[32*wd + bt] = 1'b1; else b[bt] = 1'b1;
        apply(a, b, "R2/R8 single bit");
      end

    // idle: valid drops, result holds (R5, R6)
    keep = result_o;
    @(negedge clk_i);
    src_a_i = {4{$urandom}}; src_b_i = {4{$urandom}};
    @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R5 idle", {127'd0, out_valid_o}, 128'd0);
    chk(result_o === keep, "R6 hold", result_o, keep);

    // random, and upper-B independence (R4)
    for (int n = 0; n < 300; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      apply(a, b, "R3 random");
      r1 = result_o;
      b[127:32] = ~b[127:32];
      apply(a, b, "R3 random flipped");
      chk(result_o === r1, "R4 upper B ignored", result_o, r1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule